// File: doc/BRIEF.md
# Block-Cipher Host Sequencer

This block is the register-side front end of a 128-bit block-cipher accelerator. A host reaches it over a simple 32-bit register bus. The host sets the key and the initialization vector while the block is disabled, picks an operation, a chaining scheme and a per-word swap, and then enables it. It then streams four 32-bit words into the data-in register. The fourth word starts an external cipher core through a start/done handshake. The block stays busy for a cycle count fixed by the operation, then offers the four result words for reading.

The block also guards the access sequence. Configuration and keys are frozen while it is enabled. Out-of-order data-port accesses raise sticky read and write error flags. Two request lines pace a DMA engine, one for input words and one for output words. Clearing the enable bit aborts work in progress and keeps the key and vector contents. For counter chaining the block advances the counter word after each block. For block chaining it loads the next vector. A key-derivation run writes the derived key back into the key registers.

Top module: `blkc_host_seq`

## Requirements
- R1: After reset, control reads 0, status reads 0, and irq, dma_in_req and dma_out_req are low.
- R2: Word addresses are 0 control, 1 status, 2 data-in, 3 data-out, 4..7 key words 0..3 and 8..11 vector words 0..3. The fourth accepted data-in write gives a one-cycle core_start pulse. core_din then carries the first word in bits 127:96 down to the fourth in bits 31:0. core_key is {key3..key0}, core_iv is {iv3..iv0} and core_mode is the mode field.
- R3: Control bits: [0] enable, [2:1] swap type, [4:3] mode (0 encrypt, 1 key derivation, 2 decrypt, 3 derivation plus decrypt), [6:5] chaining (0 ECB, 1 CBC, 2 CTR). Status bit 3 (busy) stays high for exactly 214, 80, 214 or 288 cycles for modes 0, 1, 2 and 3 after the fourth data-in write.
- R4: Swap type 0 keeps a word, 1 exchanges its halfwords, 2 reverses its bytes and 3 reverses its bits. The swap applies to each data-in word as it is written and to each data-out word as it is read.
- R5: In modes 0, 2 and 3, successive data-out reads return the result words from bits 127:96 downward. dma_out_req is high from completion until the fourth read.
- R6: While enable is set, writes to the swap, mode and chaining fields and to the key registers have no effect.
- R7: On completion, CTR increments vector word 0 by one (modulo 2^32). CBC loads the vector with the result in mode 0, and with the input block in modes 2 and 3. ECB leaves it unchanged.
- R8: In mode 1 the result replaces the key, {key3..key0}, and no output words are offered.
- R9: A write to data-out, or a data-in write while busy or while results are unread, sets status bit 2. Such a data-in write is discarded.
- R10: A data-out read while busy or with no results available sets status bit 1.
- R11: Completion sets status bit 0. Control bit 7 written as 1 clears it, and bit 8 clears both error flags. irq = (bit0 and enable bit 9) or (any error and enable bit 10).
- R12: Writing enable to 0 clears busy, the input and output word positions and the pending results. Key and vector contents are kept.
- R13: dma_in_req is high while the block is enabled, not busy and holding no unread results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| core_start | output | 1 | One-cycle start to the cipher core |
| core_mode | output | 2 | Operation for the core |
| core_chain | output | 2 | Chaining scheme for the core |
| core_key | output | 128 | Key block |
| core_iv | output | 128 | Vector block |
| core_din | output | 128 | Assembled input block |
| core_done | input | 1 | Core result valid pulse |
| core_dout | input | 128 | Core result block |
| irq | output | 1 | Interrupt |
| dma_in_req | output | 1 | Input word request |
| dma_out_req | output | 1 | Output word request |

## Verification
Bus reads are combinational. Their side effects, like the error flags and the output-word advance, take effect at the next rising edge. So every flag is checked on a later status read. core_start rises one cycle after the edge that takes the fourth data-in write. The bench captures core_din and core_mode at that point. Busy is counted by reading status once per cycle from the cycle after that edge. The count of busy reads must equal the mode's latency exactly. Results, the vector and the key are read only after busy has dropped.

// File: rtl/blkc_host_seq.sv
module blkc_host_seq #(
  parameter int LAT_ENC = 214,
  parameter int LAT_KD  = 80,
  parameter int LAT_DEC = 214,
  parameter int LAT_KDD = 288
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_sel,
  input  logic         bus_wr,
  input  logic [3:0]   bus_addr,
  input  logic [31:0]  bus_wdata,
  output logic [31:0]  bus_rdata,
  output logic         core_start,
  output logic [1:0]   core_mode,
  output logic [1:0]   core_chain,
  output logic [127:0] core_key,
  output logic [127:0] core_iv,
  output logic [127:0] core_din,
  input  logic         core_done,
  input  logic [127:0] core_dout,
  output logic         irq,
  output logic         dma_in_req,
  output logic         dma_out_req
);
  localparam int LM1 = (LAT_ENC > LAT_KD) ? LAT_ENC : LAT_KD;
  localparam int LM2 = (LAT_DEC > LAT_KDD) ? LAT_DEC : LAT_KDD;
  localparam int LMAX = (LM1 > LM2) ? LM1 : LM2;
  localparam int CW = $clog2(LMAX + 1);

  logic en, done_ie, err_ie, busy, out_avail, done_seen;
  logic done_f, rd_err, wr_err;
  logic [1:0] dtype, mode, chain, in_cnt, out_cnt;
  logic [31:0] key [4];
  logic [31:0] iv [4];
  logic [127:0] blk, res;
  logic [CW-1:0] cnt;
  logic [31:0] out_w;

  wire wr_s = bus_sel & bus_wr;
  wire rd_s = bus_sel & ~bus_wr;

  function automatic logic [31:0] swp(input logic [1:0] t, input logic [31:0] w);
    logic [31:0] r;
    case (t)
      2'd0: r = w;
      2'd1: r = {w[15:0], w[31:16]};
      2'd2: r = {w[7:0], w[15:8], w[23:16], w[31:24]};
      default: for (int i = 0; i < 32; i++) r[i] = w[31-i];
    endcase
    return r;
  endfunction

  function automatic logic [CW-1:0] lat(input logic [1:0] m);
    case (m)
      2'd0: return CW'(LAT_ENC - 1);
      2'd1: return CW'(LAT_KD - 1);
      2'd2: return CW'(LAT_DEC - 1);
      default: return CW'(LAT_KDD - 1);
    endcase
  endfunction

  always_comb begin
    case (out_cnt)
      2'd0: out_w = res[127:96];
      2'd1: out_w = res[95:64];
      2'd2: out_w = res[63:32];
      default: out_w = res[31:0];
    endcase
  end

  always_comb begin
    bus_rdata = 32'd0;
    case (bus_addr[3:2])
      2'd0: case (bus_addr[1:0])
        2'd0: bus_rdata = {21'd0, err_ie, done_ie, 2'd0, chain, mode, dtype, en};
        2'd1: bus_rdata = {28'd0, busy, wr_err, rd_err, done_f};
        2'd3: bus_rdata = out_avail ? swp(dtype, out_w) : 32'd0;
        default: bus_rdata = 32'd0;
      endcase
      2'd1: bus_rdata = key[bus_addr[1:0]];
      2'd2: bus_rdata = iv[bus_addr[1:0]];
      default: bus_rdata = 32'd0;
    endcase
  end

  assign core_mode   = mode;
  assign core_chain  = chain;
  assign core_key    = {key[3], key[2], key[1], key[0]};
  assign core_iv     = {iv[3], iv[2], iv[1], iv[0]};
  assign core_din    = blk;
  assign dma_in_req  = en & ~busy & ~out_avail;
  assign dma_out_req = out_avail;
  assign irq = (done_f & done_ie) | ((rd_err | wr_err) & err_ie);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0; done_ie <= 1'b0; err_ie <= 1'b0; busy <= 1'b0;
      out_avail <= 1'b0; done_seen <= 1'b0; done_f <= 1'b0;
      rd_err <= 1'b0; wr_err <= 1'b0; dtype <= 2'd0; mode <= 2'd0;
      chain <= 2'd0; in_cnt <= 2'd0; out_cnt <= 2'd0; blk <= '0;
      res <= '0; cnt <= '0; core_start <= 1'b0;
      for (int i = 0; i < 4; i++) begin key[i] <= '0; iv[i] <= '0; end
    end else begin
      core_start <= 1'b0;
      if (busy) begin
        if (core_done) done_seen <= 1'b1;
        if (cnt != '0) cnt <= cnt - CW'(1);
        else if (done_seen || core_done) begin
          busy   <= 1'b0;
          done_f <= 1'b1;
          if (mode == 2'd1) begin
            key[3] <= core_dout[127:96]; key[2] <= core_dout[95:64];
            key[1] <= core_dout[63:32];  key[0] <= core_dout[31:0];
          end else begin
            res <= core_dout; out_avail <= 1'b1; out_cnt <= 2'd0;
            if (chain == 2'd2) iv[0] <= iv[0] + 32'd1;
            else if (chain == 2'd1) begin
              if (mode == 2'd0) begin
                iv[3] <= core_dout[127:96]; iv[2] <= core_dout[95:64];
                iv[1] <= core_dout[63:32];  iv[0] <= core_dout[31:0];
              end else begin
                iv[3] <= blk[127:96]; iv[2] <= blk[95:64];
                iv[1] <= blk[63:32];  iv[0] <= blk[31:0];
              end
            end
          end
        end
      end
      if (wr_s && bus_addr[3:2] == 2'd1 && !en) key[bus_addr[1:0]] <= bus_wdata;
      if (wr_s && bus_addr[3:2] == 2'd2 && !busy) iv[bus_addr[1:0]] <= bus_wdata;
      if (wr_s && bus_addr == 4'd3) wr_err <= 1'b1;
      if (wr_s && bus_addr == 4'd2 && en) begin
        if (busy || out_avail) wr_err <= 1'b1;
        else begin
          case (in_cnt)
            2'd0: blk[127:96] <= swp(dtype, bus_wdata);
            2'd1: blk[95:64]  <= swp(dtype, bus_wdata);
            2'd2: blk[63:32]  <= swp(dtype, bus_wdata);
            default: blk[31:0] <= swp(dtype, bus_wdata);
          endcase
          in_cnt <= in_cnt + 2'd1;
          if (in_cnt == 2'd3) begin
            busy <= 1'b1; cnt <= lat(mode); core_start <= 1'b1; done_seen <= 1'b0;
          end
        end
      end
      if (rd_s && bus_addr == 4'd3) begin
        if (busy || !out_avail) rd_err <= 1'b1;
        else begin
          out_cnt <= out_cnt + 2'd1;
          if (out_cnt == 2'd3) out_avail <= 1'b0;
        end
      end
      if (wr_s && bus_addr == 4'd0) begin
        done_ie <= bus_wdata[9];
        err_ie  <= bus_wdata[10];
        if (bus_wdata[7]) done_f <= 1'b0;
        if (bus_wdata[8]) begin rd_err <= 1'b0; wr_err <= 1'b0; end
        if (!en) {chain, mode, dtype} <= bus_wdata[6:1];
        en <= bus_wdata[0];
        if (!bus_wdata[0]) begin
          busy <= 1'b0; in_cnt <= 2'd0; out_cnt <= 2'd0;
          out_avail <= 1'b0; done_seen <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/blkc_host_seq_chk.sv
module blkc_host_seq_chk #(parameter int CW = 9) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          busy,
  input logic          done_f,
  input logic [CW-1:0] cnt,
  input logic [5:0]    cfg,
  input logic          core_start,
  input logic          dma_in_req,
  input logic          dma_out_req
);
  // R2
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |=> !core_start);
  // R3
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(cnt) == '0 || !en));
  // R13
  in_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_in_req |-> (en && !busy));
  // R5
  out_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_out_req |-> !busy);
  // R6
  cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en)) |-> $stable(cfg));
  // R11
  done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_f) |-> $past(busy));
  // R12
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en) |-> !busy);
endmodule

bind blkc_host_seq blkc_host_seq_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .busy(busy), .done_f(done_f),
  .cnt(cnt), .cfg({chain, mode, dtype}), .core_start(core_start),
  .dma_in_req(dma_in_req), .dma_out_req(dma_out_req)
);

// File: tb/test_blkc_host_seq.sv
`timescale 1ns/1ps
module test_blkc_host_seq;
  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [3:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic core_start, core_done = 0, irq, dma_in_req, dma_out_req;
  logic [1:0] core_mode, core_chain;
  logic [127:0] core_key, core_iv, core_din, core_dout = 0;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  blkc_host_seq i_blkc_host_seq (.*);

  // fixed-latency core stub
  int sc = 0, starts = 0;
  logic [127:0] cap_din, cap_key, cap_iv;
  logic [1:0] cap_mode;
  always @(posedge clk) begin
    core_done <= 1'b0;
    if (core_start) begin
      cap_din <= core_din; cap_key <= core_key; cap_iv <= core_iv;
      cap_mode <= core_mode; sc <= 5; starts <= starts + 1;
    end else if (sc > 1) sc <= sc - 1;
    else if (sc == 1) begin
      core_done <= 1'b1;
      core_dout <= (cap_din ^ cap_key ^ cap_iv) + {126'd0, cap_mode};
      sc <= 0;
    end
  end

  logic [31:0] km [4];
  logic [31:0] ivm [4];

  function automatic logic [31:0] sw(input logic [1:0] t, input logic [31:0] w);
    logic [31:0] r;
    r = w;
    if (t == 1) r = (w << 16) | (w >> 16);
    if (t == 2) r = {w[7:0], w[15:8], w[23:16], w[31:24]};
    if (t == 3) for (int i = 0; i < 32; i++) r[31-i] = w[i];
    return r;
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); @(negedge clk);
    bus_sel = 0;
  endtask

  function automatic logic [31:0] cv(input int e, input int t, input int m, input int c,
                                     input int cd, input int ce, input int di, input int ei);
    return 32'(e | (t << 1) | (m << 3) | (c << 5) | (cd << 7) | (ce << 8) | (di << 9) | (ei << 10));
  endfunction

  task automatic measure(output int n);
    logic [31:0] s;
    n = 0;
    for (int k = 0; k < 1000; k++) begin
      rd(4'd1, s);
      if (!s[3]) break;
      n++;
    end
  endtask

  // runs one block with the block already enabled in (t,m,c)
  task automatic run(input logic [1:0] t, input logic [1:0] m, input logic [1:0] c,
                     input logic [31:0] w0, w1, w2, w3);
    logic [127:0] bin, fx;
    logic [31:0] r;
    int n, lat;
    int s0;
    s0 = starts;
    bin = {sw(t, w0), sw(t, w1), sw(t, w2), sw(t, w3)};
    fx = (bin ^ {km[3], km[2], km[1], km[0]} ^ {ivm[3], ivm[2], ivm[1], ivm[0]}) + {126'd0, m};
    chk("R13 in_req before", {127'd0, dma_in_req}, 1);
    wr(4'd2, w0); wr(4'd2, w1); wr(4'd2, w2); wr(4'd2, w3);
    chk("R13 in_req busy", {127'd0, dma_in_req}, 0);
    measure(n);
    lat = (m == 1) ? 80 : (m == 3) ? 288 : 214;
    chk("R3 busy cycles", 128'(n), 128'(lat));
    chk("R2 one start", 128'(starts - s0), 1);
    chk("R2 core_din order", cap_din, bin);
    chk("R2 core_mode", {126'd0, cap_mode}, {126'd0, m});
    if (m == 1) begin
      chk("R8 no out_req", {127'd0, dma_out_req}, 0);
      for (int k = 0; k < 4; k++) begin
        km[k] = fx[32*k +: 32];
        rd(4'(4 + k), r);
        chk("R8 key replaced", {96'd0, r}, {96'd0, km[k]});
      end
    end else begin
      chk("R5 out_req", {127'd0, dma_out_req}, 1);
      for (int k = 0; k < 4; k++) begin
        rd(4'd3, r);
        chk("R4 R5 out word", {96'd0, r}, {96'd0, sw(t, fx[127-32*k -: 32])});
      end
      chk("R5 out_req done", {127'd0, dma_out_req}, 0);
      if (c == 2) ivm[0] = ivm[0] + 1;
      else if (c == 1)
        for (int k = 0; k < 4; k++) ivm[k] = (m == 0) ? fx[32*k +: 32] : bin[32*k +: 32];
      for (int k = 0; k < 4; k++) begin
        rd(4'(8 + k), r);
        chk("R7 vector", {96'd0, r}, {96'd0, ivm[k]});
      end
    end
    rd(4'd1, r);
    chk("R11 done flag", {127'd0, r[0]}, 1);
  endtask

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(4'd0, r); chk("R1 ctrl", {96'd0, r}, 0);
    rd(4'd1, r); chk("R1 status", {96'd0, r}, 0);
    chk("R1 outputs", {125'd0, irq, dma_in_req, dma_out_req}, 0);

    for (int k = 0; k < 4; k++) begin
      km[k] = 32'h1357_0000 + 32'(k * 32'h1111);
      ivm[k] = 32'hA5A5_0F00 ^ 32'(k);
      wr(4'(4 + k), km[k]); wr(4'(8 + k), ivm[k]);
    end

    // sweep of swap types and modes, ECB
    for (int t = 0; t < 4; t++)
      for (int m = 0; m < 4; m++) begin
        wr(4'd0, cv(1, t, m, 0, 1, 1, 0, 0));
        run(2'(t), 2'(m), 2'd0, 32'h8001_2345 + 32'(t), 32'hF00D_C0DE ^ 32'(m << 4),
            32'h0123_4567, 32'hDEAD_BEEF + 32'(t * m));
        wr(4'd0, cv(0, 0, 0, 0, 1, 1, 0, 0));
      end

    // R6 lock
    wr(4'd0, cv(1, 0, 0, 0, 1, 1, 0, 0));
    wr(4'd0, cv(1, 3, 2, 1, 0, 0, 0, 0));
    rd(4'd0, r); chk("R6 fields locked", {96'd0, r}, 1);
    wr(4'd4, 32'hBAD0_BAD0);
    rd(4'd4, r); chk("R6 key locked", {96'd0, r}, {96'd0, km[0]});
    wr(4'd0, 0);

    // R7 CTR with wrap, then CBC encrypt and decrypt
    ivm[0] = 32'hFFFF_FFFF; wr(4'd8, ivm[0]);
    wr(4'd0, cv(1, 0, 0, 2, 1, 1, 0, 0));
    run(2'd0, 2'd0, 2'd2, 32'h11, 32'h22, 32'h33, 32'h44);
    chk("R7 ctr wrap", {96'd0, ivm[0]}, 0);
    wr(4'd0, 0);
    wr(4'd0, cv(1, 2, 0, 1, 1, 1, 0, 0));
    run(2'd2, 2'd0, 2'd1, 32'hCAFE_0001, 32'h5555_AAAA, 32'h0F0F_0F0F, 32'h7);
    wr(4'd0, 0);
    wr(4'd0, cv(1, 0, 2, 1, 1, 1, 0, 0));
    run(2'd0, 2'd2, 2'd1, 32'h9, 32'h8, 32'h7, 32'h6);
    wr(4'd0, 0);

    // R9 R10 R11 errors and interrupts
    wr(4'd0, cv(1, 0, 0, 0, 1, 1, 0, 1));
    rd(4'd3, r);
    rd(4'd1, r); chk("R10 early read", {96'd0, r}, 32'h2);
    chk("R11 err irq", {127'd0, irq}, 1);
    wr(4'd0, cv(1, 0, 0, 0, 0, 1, 0, 1));
    chk("R11 err clear", {127'd0, irq}, 0);
    wr(4'd3, 32'h1);
    rd(4'd1, r); chk("R9 dout write", {96'd0, r}, 32'h4);
    wr(4'd0, cv(1, 0, 0, 0, 1, 1, 1, 0));
    wr(4'd2, 32'hA); wr(4'd2, 32'hB); wr(4'd2, 32'hC); wr(4'd2, 32'hD);
    wr(4'd2, 32'hEEEE);
    rd(4'd3, r);
    rd(4'd1, r); chk("R9 R10 busy errors", {96'd0, r[2:1]}, 3);
    chk("R11 no done irq yet", {127'd0, irq}, 0);
    measure(n);
    chk("R11 done irq", {127'd0, irq}, 1);
    chk("R9 discarded din", cap_din, {32'hA, 32'hB, 32'hC, 32'hD});
    wr(4'd2, 32'h5);
    rd(4'd1, r); chk("R9 unread results", {96'd0, r[2]}, 1);
    wr(4'd0, cv(1, 0, 0, 0, 1, 1, 1, 0));
    rd(4'd1, r); chk("R11 done cleared", {96'd0, r[0]}, 0);
    chk("R11 irq low", {127'd0, irq}, 0);
    wr(4'd0, 0);

    // R12 abort
    wr(4'd0, cv(1, 0, 0, 0, 1, 1, 0, 0));
    wr(4'd2, 32'h7777);
    wr(4'd0, 0);
    wr(4'd0, cv(1, 0, 0, 0, 1, 1, 0, 0));
    wr(4'd2, 1); wr(4'd2, 2); wr(4'd2, 3); wr(4'd2, 4);
    repeat (20) @(negedge clk);
    wr(4'd0, 0);
    rd(4'd1, r); chk("R12 busy cleared", {96'd0, r[3]}, 0);
    chk("R12 no results", {127'd0, dma_out_req}, 0);
    rd(4'd4, r); chk("R12 key kept", {96'd0, r}, {96'd0, km[0]});
    wr(4'd0, cv(1, 0, 0, 0, 1, 1, 0, 0));
    run(2'd0, 2'd0, 2'd0, 32'h10, 32'h20, 32'h30, 32'h40);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule